// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog Reset

A free-running up-counter advances by one on every cycle where the tick strobe `tick_i` is high. Four match registers are compared against the counter. A channel records an event on the tick that carries the counter onto the channel's match value, and only if the channel's interrupt enable bit is set. A recorded event sets that channel's sticky status flag, and the flag drives the channel's interrupt line directly. Software clears a flag by writing a one to it. Any write to the counter takes effect at once, and counting continues from the written value.

Channel 3 also feeds a small watchdog state machine with three states. `WD_IDLE` is entered at reset. The transition *arm* moves it from `WD_IDLE` to `WD_ARMED` when software writes 1 to bit 0 of the watchdog register. The transition *trip* moves it from `WD_ARMED` to `WD_TRIPPED` on a channel-3 match. `WD_TRIPPED` holds until reset, and the reset request output is high throughout that state. No path leads back to `WD_IDLE` except reset.

Register access uses a single-cycle bus. A write happens at the clock edge while `bus_sel_i` and `bus_we_i` are high. Read data is a combinational decode of `bus_addr_i`. The map is: match 0 to 3 at 0x00, 0x04, 0x08 and 0x0C; counter at 0x10; status at 0x14; watchdog enable at 0x18; interrupt enable at 0x1C.

Top module: `mt_match_timer`

## Requirements
- R1: On each cycle with `tick_i` high and no counter write, the counter at 0x10 increments by one, and 0xFFFFFFFF wraps to 0.
- R2: A write to 0x10 loads the counter at that edge and overrides a tick in the same cycle. The load never records a match event, and without a tick the counter holds its value.
- R3: Match register i sits at offset 4*i (i = 0..3), is fully writable and reads back its stored value.
- R4: Status bit i is bit i of 0x14. It sets at the edge where a tick carries the counter onto match register i, but only while enable bit i (bit i of 0x1C) is set. `irq_o[i]` equals status bit i. Without a tick or a status write, `irq_o` does not change.
- R5: Writing 0x14 clears each status bit written as 1 and leaves bits written as 0 unchanged. An event on the same edge wins over the clear.
- R6: The interrupt enable register at 0x1C stores bits 11:0 of the written data and reads back zero above bit 11.
- R7: Writing 1 to bit 0 of 0x18 arms the watchdog. Writing 0 has no effect. Bit 0 of 0x18 reads 1 from arming until reset.
- R8: While armed, a channel-3 match raises `rst_req_o` whatever enable bit 3 holds. It stays high until reset and rises only at an edge where a tick occurred.
- R9: Reads of any offset not listed above return 0. Writes to such offsets change no register.
- R10: After reset, the counter, the match registers, status, enable and watchdog all read 0, and `irq_o` and `rst_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count strobe, one count per high cycle |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | Write when high with select |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 4 | Per-channel interrupt lines |
| rst_req_o | output | 1 | Watchdog reset request |

## Verification
The assertions assume that `tick_i` and the bus inputs hold known values at every sampled edge after reset. They also assume that a write whose address decodes to a register really is a write, because the checker rebuilds the counter and status write strobes from the bus inputs. The stimulus drives all inputs on the falling edge with defined values. Random traffic loads the counter just below a match value so that ticks often land on matches. Watchdog writes stay out of the random phase, so the arm and trip sequences run in directed steps with a known counter.

// File: rtl/mt_pkg.sv
package mt_pkg;

    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MATCH0  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WDOG    = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IENABLE = 8'h1C;

    localparam int unsigned MATCH_STRIDE = 4;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_ARMED   = 2'd1,
        WD_TRIPPED = 2'd2
    } wd_state_e;

endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] count_inc_o,
    output logic         advance_o
);

    assign count_inc_o = count_o + W'(1);
    assign advance_o   = tick_i & ~load_i;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            count_o <= '0;
        end else if (load_i) begin
            count_o <= load_val_i;
        end else if (tick_i) begin
            count_o <= count_inc_o;
        end
    end

endmodule

// File: rtl/mt_channel.sv
module mt_channel #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         wr_match_i,
    input  logic [W-1:0] wdata_i,
    input  logic         advance_i,
    input  logic [W-1:0] count_inc_i,
    input  logic         enable_i,
    input  logic         clear_i,
    output logic [W-1:0] match_o,
    output logic         hit_o,
    output logic         status_o
);

    // raw hit: the tick lands the counter on this match value
    assign hit_o = advance_i && (count_inc_i == match_o);

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            match_o <= '0;
        end else if (wr_match_i) begin
            match_o <= wdata_i;
        end
    end

    // event beats clear on the same edge
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            status_o <= 1'b0;
        end else if (hit_o && enable_i) begin
            status_o <= 1'b1;
        end else if (clear_i) begin
            status_o <= 1'b0;
        end
    end

endmodule

// File: rtl/mt_watchdog.sv
module mt_watchdog
    import mt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic arm_i,
    input  logic trip_i,
    output logic armed_o,
    output logic reset_req_o
);

    wd_state_e state_q;
    wd_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:    if (arm_i)  state_d = WD_ARMED;
            WD_ARMED:   if (trip_i) state_d = WD_TRIPPED;
            WD_TRIPPED: state_d = WD_TRIPPED;
            default:    state_d = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        armed_o     = (state_q != WD_IDLE);
        reset_req_o = (state_q == WD_TRIPPED);
    end

endmodule

// File: rtl/mt_match_timer.sv
module mt_match_timer
    import mt_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned IEN_W  = 12,
    parameter int unsigned WD_CH  = 3
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    output logic [NUM_CH-1:0] irq_o,
    output logic              rst_req_o
);

    localparam logic [NUM_CH-1:0] WD_MASK = NUM_CH'(1) << WD_CH;

    logic bus_wr;
    logic wr_count;
    logic wr_status;
    logic wr_wdog;
    logic wr_ien;

    assign bus_wr    = bus_sel_i & bus_we_i;
    assign wr_count  = bus_wr && (bus_addr_i == OFS_COUNT);
    assign wr_status = bus_wr && (bus_addr_i == OFS_STATUS);
    assign wr_wdog   = bus_wr && (bus_addr_i == OFS_WDOG);
    assign wr_ien    = bus_wr && (bus_addr_i == OFS_IENABLE);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;
    logic             advance;

    mt_counter #(.W(CNT_W)) u_counter (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .tick_i      (tick_i),
        .load_i      (wr_count),
        .load_val_i  (bus_wdata_i),
        .count_o     (count_q),
        .count_inc_o (count_inc),
        .advance_o   (advance)
    );

    logic [IEN_W-1:0] ien_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            ien_q <= '0;
        end else if (wr_ien) begin
            ien_q <= bus_wdata_i[IEN_W-1:0];
        end
    end

    logic [CNT_W-1:0]  match_q [NUM_CH];
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] status;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] MADDR = ADDR_W'(g * MATCH_STRIDE) + OFS_MATCH0;

        mt_channel #(.W(CNT_W)) u_ch (
            .clk_i       (clk_i),
            .rst_n_i     (rst_n_i),
            .wr_match_i  (bus_wr && (bus_addr_i == MADDR)),
            .wdata_i     (bus_wdata_i),
            .advance_i   (advance),
            .count_inc_i (count_inc),
            .enable_i    (ien_q[g]),
            .clear_i     (wr_status && bus_wdata_i[g]),
            .match_o     (match_q[g]),
            .hit_o       (hit[g]),
            .status_o    (status[g])
        );
    end

    assign irq_o = status;

    logic wd_armed;

    mt_watchdog u_wdog (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .arm_i       (wr_wdog && bus_wdata_i[0]),
        .trip_i      (|(hit & WD_MASK)),
        .armed_o     (wd_armed),
        .reset_req_o (rst_req_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFS_COUNT:   bus_rdata_o = count_q;
            OFS_STATUS:  bus_rdata_o = CNT_W'(status);
            OFS_WDOG:    bus_rdata_o = CNT_W'(wd_armed);
            OFS_IENABLE: bus_rdata_o = CNT_W'(ien_q);
            default: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (bus_addr_i == ADDR_W'(i * MATCH_STRIDE) + OFS_MATCH0) begin
                        bus_rdata_o = match_q[i];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/mt_match_timer_chk.sv
module mt_match_timer_chk
    import mt_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              tick_i,
    input logic              bus_sel_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [CNT_W-1:0]  bus_wdata_i,
    input logic [NUM_CH-1:0] irq_o,
    input logic              rst_req_o,
    input logic [CNT_W-1:0]  count_q
);

    logic cnt_wr;
    logic stat_wr;

    assign cnt_wr  = bus_sel_i && bus_we_i && (bus_addr_i == OFS_COUNT);
    assign stat_wr = bus_sel_i && bus_we_i && (bus_addr_i == OFS_STATUS);

    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (tick_i && !cnt_wr) |=> (count_q == $past(count_q) + CNT_W'(1))); // R1

    AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!tick_i && !cnt_wr) |=> $stable(count_q)); // R2

    AST_COUNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cnt_wr |=> (count_q == $past(bus_wdata_i))); // R2

    AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!tick_i && !stat_wr) |=> $stable(irq_o)); // R4

    AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (stat_wr && !tick_i) |=> ((irq_o & $past(bus_wdata_i[NUM_CH-1:0])) == '0)); // R5

    AST_RST_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rst_req_o |=> rst_req_o); // R8

    AST_RST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(rst_req_o) |-> $past(tick_i)); // R8

endmodule

bind mt_match_timer mt_match_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .tick_i      (tick_i),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .rst_req_o   (rst_req_o),
    .count_q     (count_q)
);

// File: tb/mt_match_timer_tb_top.sv
module mt_match_timer_tb_top;
    import mt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        rst_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    mt_match_timer dut_i (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .tick_i      (tick),
        .bus_sel_i   (bus_sel),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq),
        .rst_req_o   (rst_req)
    );

    // reference state
    logic [31:0] m_cnt;
    logic [31:0] m_match [NCH];
    logic [11:0] m_ien;
    logic [3:0]  m_stat;
    logic        m_arm;
    logic        m_trip;

    int checks = 0;
    int fails  = 0;

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return m_match[0];
            8'h04: return m_match[1];
            8'h08: return m_match[2];
            8'h0C: return m_match[3];
            8'h10: return m_cnt;
            8'h14: return {28'b0, m_stat};
            8'h18: return {31'b0, m_arm};
            8'h1C: return {20'b0, m_ien};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0; m_ien = '0; m_stat = '0; m_arm = 1'b0; m_trip = 1'b0;
        for (int i = 0; i < NCH; i++) m_match[i] = '0;
    endtask

    task automatic model_edge(input logic wr, input logic [7:0] a, input logic [31:0] d,
                              input logic tk);
        logic [3:0]  hitv;
        logic        adv;
        logic [31:0] inc;
        adv = tk && !(wr && a == 8'h10);
        inc = m_cnt + 32'd1;
        for (int i = 0; i < NCH; i++) hitv[i] = adv && (inc == m_match[i]);
        if (wr && a == 8'h14) m_stat = m_stat & ~d[3:0];
        m_stat = m_stat | (hitv & m_ien[3:0]);
        if (m_arm && hitv[3]) m_trip = 1'b1;
        if (wr && a == 8'h18 && d[0]) m_arm = 1'b1;
        for (int i = 0; i < NCH; i++) if (wr && a == 8'(i * 4)) m_match[i] = d;
        if (wr && a == 8'h1C) m_ien = d[11:0];
        if (wr && a == 8'h10) m_cnt = d;
        else if (tk) m_cnt = inc;
    endtask

    task automatic cycle(input logic sel, input logic we, input logic [7:0] a,
                         input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d; tick = tk;
        @(posedge clk);
        model_edge(sel && we, a, d, tk);
        #1;
        check("R4 irq_o", {28'b0, irq}, {28'b0, m_stat});
        check("R8 rst_req_o", {31'b0, rst_req}, {31'b0, m_trip});
    endtask

    task automatic idle();           cycle(1'b0, 1'b0, 8'h00, 32'h0, 1'b0); endtask
    task automatic tk1();            cycle(1'b0, 1'b0, 8'h00, 32'h0, 1'b1); endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d); cycle(1'b1, 1'b1, a, d, 1'b0); endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; tick = 1'b0;
        #1;
        check(tag, bus_rdata, exp_read(a));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; tick = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rd_all(input string tag);
        for (int a = 0; a < 8; a++) rd(8'(a * 4), tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        do_reset();

        // R10: reset state
        #1;
        check("R10 irq after reset", {28'b0, irq}, 32'h0);
        check("R10 rst_req after reset", {31'b0, rst_req}, 32'h0);
        rd_all("R10 register after reset");

        // R3: match registers
        wr(8'h00, 32'h102); wr(8'h04, 32'h102); wr(8'h08, 32'h200); wr(8'h0C, 32'h300);
        rd(8'h00, "R3 match0"); rd(8'h04, "R3 match1"); rd(8'h08, "R3 match2"); rd(8'h0C, "R3 match3");

        // R6: enable keeps bits 11:0 (channels 0, 2, 3 enabled)
        wr(8'h1C, 32'hFFFF_F00D);
        rd(8'h1C, "R6 enable model");
        check("R6 enable literal", bus_rdata, 32'h0000_000D);

        // R2 load, hold; R4 event on enabled channel only
        wr(8'h10, 32'h100);
        idle();
        rd(8'h10, "R2 count hold");
        check("R2 count literal", bus_rdata, 32'h100);
        tk1(); tk1();
        check("R4 ch0 set, ch1 disabled", {28'b0, irq}, 32'h1);
        wr(8'h10, 32'h200);
        check("R2 load onto match no event", {28'b0, irq}, 32'h1);
        tk1();
        wr(8'h10, 32'h1FF); tk1();
        check("R4 ch2 set by tick", {28'b0, irq}, 32'h5);

        // R5: write-one-to-clear, zero no effect, set beats clear
        wr(8'h14, 32'h4);
        check("R5 clear bit2", {28'b0, irq}, 32'h1);
        wr(8'h14, 32'h0);
        check("R5 write zero", {28'b0, irq}, 32'h1);
        wr(8'h10, 32'h101);
        cycle(1'b1, 1'b1, 8'h14, 32'h1, 1'b1);
        check("R5 event wins over clear", {28'b0, irq}, 32'h1);
        wr(8'h14, 32'hF);
        check("R5 clear all", {28'b0, irq}, 32'h0);

        // R1: wrap to zero matches channel 3
        wr(8'h0C, 32'h0);
        wr(8'h10, 32'hFFFF_FFFE);
        tk1();
        rd(8'h10, "R1 count FFFFFFFF");
        tk1();
        rd(8'h10, "R1 count wrapped");
        check("R1 wrap literal", bus_rdata, 32'h0);
        check("R1 wrap match ch3", {28'b0, irq}, 32'h8);

        // R9: unmapped offsets
        wr(8'h24, 32'hDEAD_BEEF);
        wr(8'h44, 32'h1234_5678);
        rd(8'h24, "R9 unmapped read 24");
        check("R9 unmapped literal", bus_rdata, 32'h0);
        rd(8'h44, "R9 unmapped read 44");
        rd_all("R9 no register changed");

        // random phase, no watchdog writes
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            int unsigned k;
            r = $urandom % 10;
            k = $urandom % 4;
            case (r)
                0: wr(8'h10, m_match[k] - ($urandom % 4));
                1: wr(8'(k * 4), $urandom % 64);
                2: wr(8'h14, $urandom);
                3: wr(8'h1C, $urandom);
                4: rd(8'(($urandom % 12) * 4), "R3 R6 random read");
                5: wr(8'h20 + 8'(($urandom % 8) * 4), $urandom);
                6: cycle(1'b1, 1'b1, 8'h14, $urandom, 1'b1);
                default: tk1();
            endcase
        end
        wr(8'h14, 32'hF);

        // R7: watchdog enable
        wr(8'h18, 32'h0);
        rd(8'h18, "R7 write zero keeps idle");
        wr(8'h18, 32'hFFFF_FFFE);
        rd(8'h18, "R7 bit0 clear no arm");
        wr(8'h18, 32'h1);
        rd(8'h18, "R7 armed");
        wr(8'h18, 32'h0);
        rd(8'h18, "R7 zero cannot disarm");
        check("R7 armed literal", bus_rdata, 32'h1);

        // R8: trip on channel 3 with its interrupt disabled
        wr(8'h1C, 32'h0);
        wr(8'h10, 32'h500);
        wr(8'h0C, 32'h502);
        tk1();
        check("R8 not yet", {31'b0, rst_req}, 32'h0);
        tk1();
        check("R8 trip", {31'b0, rst_req}, 32'h1);
        check("R8 irq3 stays low when disabled", {28'b0, irq}, 32'h0);
        wr(8'h18, 32'h0);
        idle(); idle(); idle();
        check("R8 held", {31'b0, rst_req}, 32'h1);

        do_reset();
        #1;
        check("R10 rst_req cleared", {31'b0, rst_req}, 32'h0);
        rd(8'h18, "R10 watchdog idle");

        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule